// File: doc/BRIEF.md
# Buffered Waveform Output Sequencer

This block plays a stored waveform into a parallel DAC data port, one sample per tick of a sample clock. A host fills an on-chip sample FIFO through a valid/ready write port, sets the configuration inputs and pulses `start`. Each sample leaves on `dac_data` together with a one-cycle `dac_strobe`. The sample clock is either an internal divider or an external tick input. The run can begin at once, or the block can wait for a rising edge on a hardware trigger input.

There are two playback policies. In stream-through, each sample is taken from the FIFO once, so the host must keep writing. A tick that finds the FIFO empty ends the run and sets a sticky underflow flag. In FIFO replay, the first `cfg_len` stored samples are read over and over without being removed, and host writes are refused while the run lasts. Either policy can run finitely, where `cfg_count` samples are sent and then `done` is raised, or continuously, where the run lasts until `stop`.

Top module: `wave_seq`

## Requirements
- R1: With the internal clock source and divider value N, consecutive strobes of a run are exactly N+1 clock cycles apart.
- R2: With the external clock source, each rising edge of `ext_tick` (after a two-flop synchroniser) produces exactly one sample, however long the input stays high.
- R3: In stream-through mode the samples appear on `dac_data` in the order they were written, each exactly once, each marked by a one-cycle `dac_strobe`.
- R4: In finite mode exactly `cfg_count` samples are sent. Then `done` goes to 1 and `busy` to 0. `done` clears at the next accepted start.
- R5: In continuous mode samples keep flowing until `stop`. `stop` returns the block to idle with `busy`=0 and no further strobes, and samples not yet sent stay in the FIFO.
- R6: In replay mode the sequence on `dac_data` cycles through the first `cfg_len` stored samples. Nothing is removed from the FIFO, so the same samples can be streamed afterwards.
- R7: While a replay run is busy, `wr_ready` is 0 and no write is accepted. Otherwise `wr_ready` is 1 whenever the FIFO is not full.
- R8: In stream-through mode a tick while the FIFO is empty ends the run (`busy`=0, no strobe) and sets `underflow`. `underflow` stays 1 until `clr_err`.
- R9: A start is refused, with `cfg_err` set and `busy` left at 0, when finite mode has `cfg_count`=0, or when replay mode has `cfg_len` equal to 0, above the FIFO depth, or above the number of stored samples. `cfg_err` stays set until `clr_err`.
- R10: With `cfg_trig`=1, a start makes the block busy but sends no sample until a rising edge on the synchronised `trig_in`.
- R11: `dac_data` holds its last value in every cycle without a strobe, including after the run has ended.
- R12: After reset: `busy`, `done`, `underflow`, `cfg_err` and `dac_strobe` are 0, `dac_data` is 0, and `wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cont | input | 1 | 1 = continuous run, 0 = finite run |
| cfg_replay | input | 1 | 1 = FIFO replay, 0 = stream-through |
| cfg_ext | input | 1 | 1 = external tick, 0 = internal divider |
| cfg_trig | input | 1 | 1 = wait for trigger edge after start |
| cfg_div | input | DVW | Internal divider value N (period N+1) |
| cfg_count | input | CW | Samples to send in a finite run |
| cfg_len | input | AW+1 | Waveform length in replay mode |
| start | input | 1 | Begin a run (sampled in idle or ended state) |
| stop | input | 1 | Abort an armed or running run |
| clr_err | input | 1 | Clear underflow and cfg_err |
| trig_in | input | 1 | Asynchronous start trigger |
| ext_tick | input | 1 | Asynchronous external sample clock |
| wr_valid | input | 1 | Host write request |
| wr_data | input | DW | Host write sample |
| wr_ready | output | 1 | Write accepted when high with wr_valid |
| dac_data | output | DW | Sample presented to the DAC |
| dac_strobe | output | 1 | One-cycle pulse for a new sample |
| busy | output | 1 | Armed or running |
| done | output | 1 | Finite run completed |
| underflow | output | 1 | Sticky empty-FIFO error |
| cfg_err | output | 1 | Sticky refused-start error |

## Verification
On every cycle, the bound checker confirms several things. Strobes appear only while the block is busy, and `dac_data` holds between strobes. `done` and `busy` are never high together, and both error flags stay set until cleared. A replay run never shows `wr_ready`. An underflow or a refused start always leaves the block not busy. Other properties need whole scenarios run by the bench, which compares every emitted sample against a scoreboard queue. These are the sample order and the replay wrap, the exact finite count, the spacing set by the divider, one sample per external edge, the hold until the trigger edge, and what a stop leaves behind in the FIFO.

// File: rtl/wave_seq.sv
module wave_seq #(
  parameter int DW    = 12,
  parameter int DEPTH = 16,
  parameter int CW    = 16,
  parameter int DVW   = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_cont,
  input  logic          cfg_replay,
  input  logic          cfg_ext,
  input  logic          cfg_trig,
  input  logic [DVW-1:0] cfg_div,
  input  logic [CW-1:0] cfg_count,
  input  logic [AW:0]   cfg_len,
  input  logic          start,
  input  logic          stop,
  input  logic          clr_err,
  input  logic          trig_in,
  input  logic          ext_tick,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic [DW-1:0] dac_data,
  output logic          dac_strobe,
  output logic          busy,
  output logic          done,
  output logic          underflow,
  output logic          cfg_err
);
  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_RUN, S_END} st_t;
  st_t st;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp, ridx, m_len;
  logic [CW-1:0] emitted, m_count;
  logic [DVW-1:0] divcnt, m_div;
  logic          m_cont, m_replay, m_ext;
  logic [2:0]    ext_s, trg_s;

  wire [AW:0] fill    = wp - rp;
  wire        empty   = fill == '0;
  wire        full    = fill == DEPTH_L;
  wire        ext_rise = ext_s[1] & ~ext_s[2];
  wire        trg_rise = trg_s[1] & ~trg_s[2];
  wire        running = st == S_RUN;
  wire        tick    = running && (m_ext ? ext_rise : divcnt == m_div);
  wire        can_emit = m_replay || !empty;
  wire        last    = !m_cont && emitted == m_count - 1'b1;
  wire        pop     = tick && !stop && !m_replay && !empty;
  wire [AW-1:0] rd_addr = m_replay ? rp[AW-1:0] + ridx[AW-1:0] : rp[AW-1:0];
  wire        bad_cfg = (cfg_replay && (cfg_len == '0 || cfg_len > DEPTH_L || cfg_len > fill))
                     || (!cfg_cont && cfg_count == '0);

  assign busy     = st == S_ARMED || st == S_RUN;
  assign wr_ready = !full && !(busy && m_replay);
  wire   push     = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      ext_s <= '0;
      trg_s <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      ext_s <= {ext_s[1:0], ext_tick};
      trg_s <= {trg_s[1:0], trig_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      m_cont <= 1'b0;
      m_replay <= 1'b0;
      m_ext <= 1'b0;
      m_div <= '0;
      m_count <= '0;
      m_len <= '0;
      ridx <= '0;
      emitted <= '0;
      divcnt <= '0;
      dac_data <= '0;
      dac_strobe <= 1'b0;
      done <= 1'b0;
      underflow <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      dac_strobe <= 1'b0;
      if (clr_err) begin
        underflow <= 1'b0;
        cfg_err <= 1'b0;
      end
      if (running && divcnt != m_div) divcnt <= divcnt + 1'b1;
      else divcnt <= '0;
      case (st)
        S_IDLE, S_END: if (start) begin
          if (bad_cfg) cfg_err <= 1'b1;
          else begin
            m_cont <= cfg_cont;
            m_replay <= cfg_replay;
            m_ext <= cfg_ext;
            m_div <= cfg_div;
            m_count <= cfg_count;
            m_len <= cfg_len;
            ridx <= '0;
            emitted <= '0;
            divcnt <= '0;
            done <= 1'b0;
            st <= cfg_trig ? S_ARMED : S_RUN;
          end
        end
        S_ARMED: begin
          if (stop) st <= S_IDLE;
          else if (trg_rise) st <= S_RUN;
        end
        S_RUN: begin
          if (stop) st <= S_IDLE;
          else if (tick) begin
            if (can_emit) begin
              dac_data <= mem[rd_addr];
              dac_strobe <= 1'b1;
              emitted <= emitted + 1'b1;
              ridx <= (ridx == m_len - 1'b1) ? '0 : ridx + 1'b1;
              if (last) begin
                st <= S_END;
                done <= 1'b1;
              end
            end else begin
              underflow <= 1'b1;
              st <= S_END;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wave_seq_chk.sv
module wave_seq_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_err,
  input logic          busy,
  input logic          done,
  input logic          underflow,
  input logic          cfg_err,
  input logic          wr_ready,
  input logic          dac_strobe,
  input logic [DW-1:0] dac_data,
  input logic          m_replay
);
  a_r3_strobe_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    dac_strobe |-> $past(busy));
  a_r11_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_strobe |-> $stable(dac_data));
  a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
  a_r7_no_write_in_replay: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && m_replay) |-> !wr_ready);
  a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !clr_err) |=> underflow);
  a_r8_underflow_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow) |-> !busy);
  a_r9_cfg_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !clr_err) |=> cfg_err);
  a_r9_refused_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> !busy);
endmodule

bind wave_seq wave_seq_chk #(.DW(DW)) u_chk (.*);

// File: tb/wave_seq_tb.sv
module wave_seq_tb;
  localparam int DW = 12, DEPTH = 16, CW = 16, DVW = 16, AW = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_cont = 0, cfg_replay = 0, cfg_ext = 0, cfg_trig = 0;
  logic [DVW-1:0] cfg_div = '0;
  logic [CW-1:0] cfg_count = '0;
  logic [AW:0] cfg_len = '0;
  logic start = 0, stop = 0, clr_err = 0, trig_in = 0, ext_tick = 0;
  logic wr_valid = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, dac_strobe, busy, done, underflow, cfg_err;
  logic [DW-1:0] dac_data;

  wave_seq #(.DW(DW), .DEPTH(DEPTH), .CW(CW), .DVW(DVW)) u_dut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, last_cyc = -1, exp_gap = 0;
  logic [DW-1:0] sb [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && dac_strobe) begin
      if (sb.size() == 0) check(0, "R3 unexpected strobe", dac_data, -1);
      else begin
        automatic logic [DW-1:0] e = sb.pop_front();
        check(dac_data == e, "R3/R6 sample value", dac_data, e);
      end
      if (exp_gap > 0 && last_cyc >= 0)
        check(cyc - last_cyc == exp_gap, "R1 strobe spacing", cyc - last_cyc, exp_gap);
      last_cyc = cyc;
    end
    if (cyc > 100000) begin
      check(0, "watchdog", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic write(input logic [DW-1:0] d);
    @(posedge clk); #1;
    wr_valid = 1; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 0;
  endtask

  task automatic expect_s(input logic [DW-1:0] d);
    sb.push_back(d);
  endtask

  task automatic go(input bit cont, input bit rep, input bit ext, input bit trg,
                    input int div, input int cnt, input int len);
    @(posedge clk); #1;
    cfg_cont = cont; cfg_replay = rep; cfg_ext = ext; cfg_trig = trg;
    cfg_div = DVW'(div); cfg_count = CW'(cnt); cfg_len = (AW+1)'(len);
    exp_gap = ext ? 0 : div + 1; last_cyc = -1;
    start = 1;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear();
    @(posedge clk); #1; clr_err = 1;
    @(posedge clk); #1; clr_err = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !underflow && !cfg_err && !dac_strobe, "R12 flags after reset",
          {busy, done, underflow, cfg_err, dac_strobe}, 0);
    check(dac_data == 0 && wr_ready, "R12 data/ready after reset", dac_data, 0);

    // R4 finite stream, R1 internal spacing
    for (int i = 0; i < 4; i++) begin write(DW'(16 + i)); expect_s(DW'(16 + i)); end
    go(0, 0, 0, 0, 3, 4, 0);
    wait_idle();
    check(done && !busy, "R4 done after count", done, 1);
    check(sb.size() == 0, "R4 all samples sent", sb.size(), 0);

    // R9 zero count refused
    go(0, 0, 0, 0, 1, 0, 0);
    @(negedge clk);
    check(cfg_err && !busy, "R9 zero count refused", cfg_err, 1);
    clear();
    @(negedge clk);
    check(!cfg_err, "R9 cfg_err cleared", cfg_err, 0);

    // R6 replay finite, R7 writes refused
    write(12'hA01); write(12'hB02); write(12'hC03);
    for (int i = 0; i < 7; i++) expect_s(i % 3 == 0 ? 12'hA01 : i % 3 == 1 ? 12'hB02 : 12'hC03);
    go(0, 1, 0, 0, 1, 7, 3);
    @(negedge clk);
    check(busy && !wr_ready, "R7 wr_ready low in replay", wr_ready, 0);
    @(posedge clk); #1; wr_valid = 1; wr_data = 12'hFFF;
    @(posedge clk); #1; wr_valid = 0;
    wait_idle();
    check(done && sb.size() == 0, "R6 replay count and wrap", sb.size(), 0);
    check(wr_ready, "R7 wr_ready back after run", wr_ready, 1);

    // R9 replay length above stored samples
    go(1, 1, 0, 0, 1, 0, 5);
    @(negedge clk);
    check(cfg_err && !busy, "R9 replay length refused", cfg_err, 1);
    clear();

    // R2 external ticks drain the replayed waveform (R6 kept contents)
    expect_s(12'hA01); expect_s(12'hB02); expect_s(12'hC03);
    go(0, 0, 1, 0, 0, 3, 0);
    for (int p = 0; p < 3; p++) begin
      @(posedge clk); #1 ext_tick = 1;
      repeat (10) @(posedge clk);
      #1 ext_tick = 0;
      repeat (6) @(posedge clk);
      check(sb.size() == 2 - p, "R2 one sample per edge", sb.size(), 2 - p);
    end
    wait_idle();
    check(done, "R2 external run done", done, 1);

    // R10 trigger gating
    write(12'h111); write(12'h222); expect_s(12'h111); expect_s(12'h222);
    go(0, 0, 0, 1, 0, 2, 0);
    repeat (10) @(negedge clk);
    check(busy && sb.size() == 2, "R10 no sample before trigger", sb.size(), 2);
    @(posedge clk); #1 trig_in = 1;
    repeat (2) @(posedge clk); #1 trig_in = 0;
    wait_idle();
    check(sb.size() == 0 && done, "R10 run after trigger", sb.size(), 0);

    // R5 continuous with stop, R11 hold
    for (int i = 0; i < 4; i++) begin write(DW'(12'h300 + i)); expect_s(DW'(12'h300 + i)); end
    go(1, 0, 0, 0, 4, 0, 0);
    for (int i = 0; i < 3000 && sb.size() > 2; i++) @(negedge clk);
    stop = 1;
    @(posedge clk); #1 stop = 0;
    repeat (12) @(negedge clk);
    check(!busy && !done, "R5 stop returns idle", busy, 0);
    check(sb.size() == 2, "R5 no strobe after stop", sb.size(), 2);
    check(dac_data == 12'h301, "R11 data held after stop", dac_data, 12'h301);

    // R8 underflow after the two remaining samples
    go(1, 0, 0, 0, 2, 0, 0);
    wait_idle();
    check(sb.size() == 0, "R5 leftover samples kept", sb.size(), 0);
    check(underflow && !busy, "R8 underflow ends run", underflow, 1);
    repeat (5) @(negedge clk);
    check(underflow, "R8 underflow sticky", underflow, 1);
    check(dac_data == 12'h303, "R11 data held after underflow", dac_data, 12'h303);
    clear();
    @(negedge clk);
    check(!underflow, "R8 cleared by clr_err", underflow, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule